// File: doc/BRIEF.md
# DMA Completion Interrupt Controller

This block is the register-mapped control and interrupt logic that sits beside a multi-channel DMA engine. Software writes a control word per channel; when that word asks for a transfer and the channel is enabled in a global enable register, the block sends a one-cycle start request to the transfer engine. When the engine later reports completion with a done pulse, the block clears the channel's busy bit. If the channel's completion interrupt is enabled, it also records a per-channel completion flag and raises a shared DMA bit in an interrupt status register.

The interrupt status register also collects an external audio interrupt. A mask register selects which status bits drive the single interrupt output. Clearing follows two different rules. In the DMA interrupt control register, the upper flag bits are cleared by writing ones. In the status register, a bit is kept only when it is written as one and is also enabled in the mask. Reads return register contents one cycle after the request and never change any state.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset every register reads as zero, `irq` is low and no `xfer_start` bit is high. Word indexes: channel n control at n (0..3), global enable at 8, interrupt control at 9, status at 10, mask at 11. Any other index reads zero.
- R2: A write to channel n's control word stores the written value. When written bit 24 is one and bit 4*n+3 of the global enable register is one, `xfer_start[n]` is high for exactly the cycle after the write.
- R3: A control write with bit 24 clear, or to a channel whose enable bit is clear, produces no start pulse. The stored word still holds bit 24 as written.
- R4: A `xfer_done[n]` pulse while bit 24 of channel n's control word is set completes the transfer and clears that bit. A done pulse while bit 24 is clear has no effect on any register.
- R5: On completion of channel n with interrupt control bit 16+n set, flag bit 24+n of the interrupt control register is set and status bit 3 is set. When bit 16+n is clear, neither bit changes.
- R6: A write to the interrupt control register replaces bits 23:0 with the written value. Each of bits 31:24 written as one is cleared, and each written as zero keeps its value.
- R7: A write to the status register leaves it equal to old status AND mask AND written value.
- R8: A high `audio_irq` in a cycle sets status bit 9.
- R9: `irq` equals the OR of (status AND mask), one cycle after those registers hold their values.
- R10: A status or flag set event in the same cycle as a clearing write to the same register wins, so the bit ends up set.
- R11: A read with `rd_en` gives `rd_valid` and the addressed register on `rd_data` one cycle later, and repeated reads return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Word index of the write |
| wr_data | input | 32 | Write value |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | AW | Word index of the read |
| rd_data | output | 32 | Read value, registered |
| rd_valid | output | 1 | High the cycle after `rd_en` |
| xfer_start | output | NUM_CH | One-cycle start request per channel |
| xfer_done | input | NUM_CH | Completion pulse per channel from the transfer engine |
| audio_irq | input | 1 | External audio interrupt source |
| irq | output | 1 | Shared interrupt output |

## Verification
The assertions assume that the transfer engine pulses `xfer_done` only for channels it has actually started, or, if not, that the block's own busy check filters the pulse. They also assume that a new write to a channel control word never arrives in the cycle right after the previous one to the same channel. The stimulus keeps every write and done pulse to one cycle with idle cycles between control writes. Done pulses are aimed both at busy and at idle channels, so the filtering is exercised. The only collision it drives on purpose is a completion together with clearing writes to both interrupt registers.

// File: rtl/dic_pkg.sv
package dic_pkg;
  localparam int DW          = 32;
  localparam int START_BIT   = 24;
  localparam int IRQEN_BASE  = 16;
  localparam int FLAG_BASE   = 24;
  localparam int DMA_STAT    = 3;
  localparam int AUDIO_STAT  = 9;
  localparam int IDX_ENABLE  = 8;
  localparam int IDX_ICTL    = 9;
  localparam int IDX_STATUS  = 10;
  localparam int IDX_MASK    = 11;

  function automatic int enable_pos(input int ch);
    return 4 * ch + 3;
  endfunction
endpackage

// File: rtl/dic_chan.sv
module dic_chan
  import dic_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hit,
  input  logic [DW-1:0] wr_data,
  input  logic          chan_en,
  input  logic          done,
  output logic [DW-1:0] ctrl_q,
  output logic          start_q,
  output logic          complete
);
  logic busy;
  assign busy     = ctrl_q[START_BIT];
  assign complete = done && busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= wr_hit && wr_data[START_BIT] && chan_en;
      if (wr_hit)
        ctrl_q <= wr_data;
      else if (complete)
        ctrl_q[START_BIT] <= 1'b0;
    end
  end

  // R2
  start_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    start_q |-> $past(wr_hit && wr_data[START_BIT] && chan_en));

  // R4
  busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (done && busy && !wr_hit) |=> !ctrl_q[START_BIT]);
endmodule

// File: rtl/dic_ictl.sv
module dic_ictl
  import dic_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [DW-1:0]     wr_data,
  input  logic [NUM_CH-1:0] complete,
  output logic [DW-1:0]     ictl_q,
  output logic              dma_evt
);
  localparam int LOW_W  = FLAG_BASE;
  localparam int HIGH_W = DW - FLAG_BASE;

  logic [NUM_CH-1:0] set_evt;
  logic [DW-1:0]     base;
  logic [DW-1:0]     nxt;

  assign set_evt = complete & ictl_q[IRQEN_BASE +: NUM_CH];
  assign dma_evt = |set_evt;

  always_comb begin
    base = ictl_q;
    if (wr_hit) begin
      base[LOW_W-1:0]  = wr_data[LOW_W-1:0];
      base[DW-1:LOW_W] = ictl_q[DW-1:LOW_W] & ~wr_data[DW-1:LOW_W];
    end
    nxt = base;
    nxt[FLAG_BASE +: NUM_CH] = base[FLAG_BASE +: NUM_CH] | set_evt;
  end

  always_ff @(posedge clk) begin
    if (rst) ictl_q <= '0;
    else     ictl_q <= nxt;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_flag_chk
      // R5
      flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ictl_q[FLAG_BASE+g]) |-> $past(complete[g] && ictl_q[IRQEN_BASE+g]));
      // R10
      flag_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (complete[g] && ictl_q[IRQEN_BASE+g]) |=> ictl_q[FLAG_BASE+g]);
    end
  endgenerate

  // R6
  upper_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && complete == '0) |=>
      ((ictl_q[DW-1:LOW_W] & ~$past(ictl_q[DW-1:LOW_W])) == '0));

  logic unused_w;
  assign unused_w = ^HIGH_W;
endmodule

// File: rtl/dic_stat.sv
module dic_stat
  import dic_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stat,
  input  logic          wr_mask,
  input  logic [DW-1:0] wr_data,
  input  logic          dma_evt,
  input  logic          audio,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] mask_q,
  output logic          irq_q
);
  logic [DW-1:0] nxt;

  always_comb begin
    nxt = wr_stat ? (stat_q & mask_q & wr_data) : stat_q;
    nxt[DMA_STAT]   = nxt[DMA_STAT] | dma_evt;
    nxt[AUDIO_STAT] = nxt[AUDIO_STAT] | audio;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= nxt;
      if (wr_mask) mask_q <= wr_data;
      irq_q  <= |(stat_q & mask_q);
    end
  end

  // R8
  audio_set_chk: assert property (@(posedge clk) disable iff (rst)
    audio |=> stat_q[AUDIO_STAT]);

  // R10
  dma_set_chk: assert property (@(posedge clk) disable iff (rst)
    dma_evt |=> stat_q[DMA_STAT]);

  // R9
  irq_high_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(|(stat_q & mask_q)));

  // R9
  irq_low_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_q |-> !$past(|(stat_q & mask_q)));

  // R7
  stat_no_new_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !dma_evt && !audio) |=> ((stat_q & ~$past(stat_q)) == '0));
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dic_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic [NUM_CH-1:0] xfer_start,
  input  logic [NUM_CH-1:0] xfer_done,
  input  logic              audio_irq,
  output logic              irq
);
  logic [DW-1:0]     ctrl  [NUM_CH];
  logic [NUM_CH-1:0] complete;
  logic [DW-1:0]     en_q;
  logic [DW-1:0]     ictl_q;
  logic [DW-1:0]     stat_q;
  logic [DW-1:0]     mask_q;
  logic              dma_evt;
  logic [DW-1:0]     rd_mux;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (wr_en && wr_addr == AW'(IDX_ENABLE)) en_q <= wr_data;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      dic_chan u_chan (
        .clk      (clk),
        .rst      (rst),
        .wr_hit   (wr_en && wr_addr == AW'(g)),
        .wr_data  (wr_data),
        .chan_en  (en_q[enable_pos(g)]),
        .done     (xfer_done[g]),
        .ctrl_q   (ctrl[g]),
        .start_q  (xfer_start[g]),
        .complete (complete[g])
      );
    end
  endgenerate

  dic_ictl #(.NUM_CH(NUM_CH)) u_ictl (
    .clk      (clk),
    .rst      (rst),
    .wr_hit   (wr_en && wr_addr == AW'(IDX_ICTL)),
    .wr_data  (wr_data),
    .complete (complete),
    .ictl_q   (ictl_q),
    .dma_evt  (dma_evt)
  );

  dic_stat u_stat (
    .clk     (clk),
    .rst     (rst),
    .wr_stat (wr_en && wr_addr == AW'(IDX_STATUS)),
    .wr_mask (wr_en && wr_addr == AW'(IDX_MASK)),
    .wr_data (wr_data),
    .dma_evt (dma_evt),
    .audio   (audio_irq),
    .stat_q  (stat_q),
    .mask_q  (mask_q),
    .irq_q   (irq)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (rd_addr == AW'(i)) rd_mux = ctrl[i];
    if (rd_addr == AW'(IDX_ENABLE)) rd_mux = en_q;
    if (rd_addr == AW'(IDX_ICTL))   rd_mux = ictl_q;
    if (rd_addr == AW'(IDX_STATUS)) rd_mux = stat_q;
    if (rd_addr == AW'(IDX_MASK))   rd_mux = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  // R11
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));

  // R1
  start_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(xfer_start) || !$stable(wr_addr) || $past(wr_en));
endmodule

// File: tb/dma_irq_ctrl_test.sv
`timescale 1ns/1ps
module dma_irq_ctrl_test;
  localparam int NUM_CH = 4;
  localparam int AW     = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic              rd_en = 1'b0;
  logic [AW-1:0]     rd_addr = '0;
  logic [31:0]       rd_data;
  logic              rd_valid;
  logic [NUM_CH-1:0] xfer_start;
  logic [NUM_CH-1:0] xfer_done = '0;
  logic              audio_irq = 1'b0;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  dma_irq_ctrl #(.NUM_CH(NUM_CH), .AW(AW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .xfer_start(xfer_start), .xfer_done(xfer_done), .audio_irq(audio_irq), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read values as results appear
  always @(negedge clk) begin
    if (rd_valid) begin
      if (q_exp.size() == 0) begin
        check("R11 unexpected rd_valid", 32'd1, 32'd0);
      end else begin
        check(q_tag.pop_front(), rd_data, q_exp.pop_front());
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = AW'(a);
    q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic done_pulse(input logic [NUM_CH-1:0] m);
    @(negedge clk);
    xfer_done = m;
    @(negedge clk);
    xfer_done = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 start", {28'd0, xfer_start}, 32'd0);
    for (int i = 0; i < 12; i++) rd(i, 32'd0, "R1 reset read");

    wr(8, 32'h0000_0808);              // enable ch0 (bit3) and ch2 (bit11)
    rd(8, 32'h0000_0808, "R1 enable reg");

    // R2 start pulse for one cycle
    wr(0, 32'h0100_0005);
    check("R2 start pulse", {28'd0, xfer_start}, 32'h1);
    idle(1);
    check("R2 start single", {28'd0, xfer_start}, 32'h0);
    rd(0, 32'h0100_0005, "R2 ctrl0 readback");

    // R3 no start when disabled or bit 24 clear
    wr(1, 32'h0100_0000);
    check("R3 disabled channel", {28'd0, xfer_start}, 32'h0);
    wr(2, 32'h0000_0001);
    check("R3 bit24 clear", {28'd0, xfer_start}, 32'h0);
    rd(1, 32'h0100_0000, "R3 ctrl1 keeps busy");

    // R6 low bits written
    wr(9, 32'h0005_0000);
    rd(9, 32'h0005_0000, "R6 ictl low write");

    // R4 done on idle channel ignored
    done_pulse(4'b0100);
    rd(2, 32'h0000_0001, "R4 idle done ctrl2");
    rd(9, 32'h0005_0000, "R4 idle done ictl");
    rd(10, 32'h0, "R4 idle done status");

    // R4/R5 completion of ch0 with interrupt enabled
    done_pulse(4'b0001);
    rd(0, 32'h0000_0005, "R4 busy cleared");
    rd(9, 32'h0105_0000, "R5 flag set");
    rd(10, 32'h0000_0008, "R5 status bit3");
    check("R9 irq masked off", {31'd0, irq}, 32'd0);

    // R5 completion of ch1 without interrupt enable
    done_pulse(4'b0010);
    rd(1, 32'h0, "R4 ctrl1 cleared");
    rd(9, 32'h0105_0000, "R5 no flag ch1");

    // R9 mask enables irq
    wr(11, 32'h0000_0208);
    idle(2);
    check("R9 irq high", {31'd0, irq}, 32'd1);

    // R8 audio source
    @(negedge clk); audio_irq = 1'b1;
    @(negedge clk); audio_irq = 1'b0;
    rd(10, 32'h0000_0208, "R8 status bit9");

    // R7 status write
    wr(10, 32'h0000_0200);
    rd(10, 32'h0000_0200, "R7 status and-write");
    idle(2);
    check("R9 irq still high", {31'd0, irq}, 32'd1);
    wr(11, 32'h0000_0008);
    idle(2);
    check("R9 irq low", {31'd0, irq}, 32'd0);
    wr(10, 32'hFFFF_FFFF);
    rd(10, 32'h0, "R7 masked-out bit cleared");

    // R6 split write
    wr(9, 32'h02AB_CDEF);
    rd(9, 32'h01AB_CDEF, "R6 zero keeps flag");
    wr(9, 32'h0105_0000);
    rd(9, 32'h0005_0000, "R6 one clears flag");

    // R10 set beats clear in the same cycle
    wr(0, 32'h0100_0000);
    check("R2 restart pulse", {28'd0, xfer_start}, 32'h1);
    idle(1);
    @(negedge clk);
    xfer_done = 4'b0001; wr_en = 1'b1; wr_addr = AW'(9); wr_data = 32'h0105_0000;
    @(negedge clk);
    xfer_done = '0; wr_addr = AW'(10); wr_data = 32'h0;
    @(negedge clk);
    wr_en = 1'b0;
    rd(9, 32'h0105_0000, "R10 flag wins");
    // status bit3 was set by the completion, then a zero write to status came
    // the next cycle with no event, so it is cleared
    rd(10, 32'h0, "R7 later clear");
    @(negedge clk);
    wr(0, 32'h0100_0000);
    idle(1);
    @(negedge clk);
    xfer_done = 4'b0001; wr_en = 1'b1; wr_addr = AW'(10); wr_data = 32'h0;
    @(negedge clk);
    xfer_done = '0; wr_en = 1'b0;
    rd(10, 32'h0000_0008, "R10 status set wins");

    // R11 side-effect free reads and unmapped index
    rd(10, 32'h0000_0008, "R11 repeat read");
    rd(5, 32'h0, "R11 unmapped");
    idle(3);
    check("R11 queue drained", q_exp.size(), 32'd0);
    finish_run();
  end
endmodule